// File: doc/BRIEF.md
# Seven-Function Arithmetic/Logic Unit with Status Flags

This block is a 16-bit arithmetic/logic unit that evaluates one of seven functions on two operands and a carry input. A 3-bit function code picks the function. Four codes are bitwise operations. Three codes are arithmetic: addition with carry, and subtraction with borrow in either direction. The eighth code is reserved and gives a fixed, known result. Along with the result, the unit returns a carry output and three status flags: zero, sign and signed overflow.

All three arithmetic functions share one adder. For the reversed subtraction, a swap stage exchanges the operands first. An invert stage then complements the second adder operand and the carry input for both subtraction codes, because x − y − c equals x + ~y + ~c. Overflow is the XOR of the carry into the most significant bit and the carry out of it.

The function datapath itself is combinational. Its result and flags are captured in output registers on the rising clock edge, so each output reflects the inputs that were present at the previous edge. A synchronous active-high reset clears these registers.

Top module: `alu_seven_fn`

## Requirements
- R1: While the reset input is high at a rising edge, the outputs become result = 0, carry_out = 0, ovf_flag = 0, sign_flag = 0 and zero_flag = 1. Otherwise every output shows the function of the inputs sampled at the most recent rising edge.
- R2: The bitwise codes are: 0 gives op_a AND op_b, 1 gives op_a OR op_b, 2 gives op_a XOR op_b, and 3 gives the bitwise complement of op_a. carry_in has no effect on these codes.
- R3: For codes 0 to 3, carry_out and ovf_flag are both 0.
- R4: Code 4 gives op_a + op_b + carry_in. result holds the low 16 bits and carry_out holds bit 16 of the sum.
- R5: Code 5 gives op_a − op_b − carry_in modulo 2^16. carry_out is 1 exactly when no borrow occurs, that is, when op_a ≥ op_b + carry_in taken as unsigned values.
- R6: Code 6 gives op_b − op_a − carry_in modulo 2^16. carry_out is 1 exactly when op_b ≥ op_a + carry_in taken as unsigned values.
- R7: For codes 4 to 6, ovf_flag is 1 exactly when the true two's-complement result of the operation lies outside the range −32768 to 32767.
- R8: Code 7 gives result = 0, carry_out = 0 and ovf_flag = 0, whatever the operands and carry_in are.
- R9: zero_flag is 1 exactly when all 16 bits of result are 0.
- R10: sign_flag equals bit 15 of result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; outputs are captured on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry for addition, borrow for the subtractions |
| func_sel | input | 3 | Function code, 0 to 7 |
| result | output | 16 | Registered function result |
| carry_out | output | 1 | Registered carry (1 means no borrow when subtracting) |
| zero_flag | output | 1 | Registered flag: result is all zeros |
| sign_flag | output | 1 | Registered copy of the result's top bit |
| ovf_flag | output | 1 | Registered signed-overflow flag |

## Verification
The bench builds the unit with its default 16-bit width. At this width the signed limits can be reached directly: 0x7FFF + 1 and 0x8000 − 1 overflow, and so do the reversed-subtraction versions of these cases. The carry chain can also ripple across all 16 bits, as in 0xFFFF + 0 + 1. The bench computes the expected values with whole-integer arithmetic, in both signed and unsigned forms, so it does not depend on the adder structure. Each code is tested with the carry input both low and high, with random operands, and with results that produce both states of the zero and sign flags.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int FN_W = 3;

  typedef enum logic [FN_W-1:0] {
    FN_AND  = 3'd0,
    FN_OR   = 3'd1,
    FN_XOR  = 3'd2,
    FN_NOTA = 3'd3,
    FN_ADD  = 3'd4,
    FN_SUB  = 3'd5,
    FN_SUBR = 3'd6,
    FN_RSVD = 3'd7
  } alu_fn_e;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic [FN_W-1:0] fn,
  output logic [W-1:0]    y
);
  always_comb begin
    case (alu_fn_e'(fn))
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_NOTA: y = ~a;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/alu_arith_unit.sv
module alu_arith_unit
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            cin,
  input  logic [FN_W-1:0] fn,
  output logic [W-1:0]    sum,
  output logic            cout,
  output logic            ovr
);
  localparam int LOW_W = W - 1;

  logic          swap_en, inv_en, c_eff, c_msb, s_msb;
  logic [W-1:0]  x_op, y_sw, y_op;
  logic [LOW_W-1:0] s_low;

  assign swap_en = (alu_fn_e'(fn) == FN_SUBR);
  assign inv_en  = (alu_fn_e'(fn) == FN_SUB) || (alu_fn_e'(fn) == FN_SUBR);

  // swap stage, then invert stage
  assign x_op  = swap_en ? b : a;
  assign y_sw  = swap_en ? a : b;
  assign y_op  = inv_en ? ~y_sw : y_sw;
  assign c_eff = inv_en ? ~cin : cin;

  // low bits and top bit are added apart, so the carry into the top bit is visible
  assign {c_msb, s_low} = {1'b0, x_op[LOW_W-1:0]} + {1'b0, y_op[LOW_W-1:0]}
                        + {{LOW_W{1'b0}}, c_eff};
  assign {cout, s_msb}  = {1'b0, x_op[W-1]} + {1'b0, y_op[W-1]} + {1'b0, c_msb};

  assign sum = {s_msb, s_low};
  assign ovr = c_msb ^ cout;
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
  parameter int W = 16
) (
  input  logic [W-1:0] y,
  output logic         zero,
  output logic         sign
);
  assign zero = ~|y;
  assign sign = y[W-1];
endmodule

// File: rtl/alu_seven_fn.sv
module alu_seven_fn
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    op_a,
  input  logic [W-1:0]    op_b,
  input  logic            carry_in,
  input  logic [FN_W-1:0] func_sel,
  output logic [W-1:0]    result,
  output logic            carry_out,
  output logic            zero_flag,
  output logic            sign_flag,
  output logic            ovf_flag
);
  logic [W-1:0] lg_y, ar_y, y_n;
  logic         ar_c, ar_v, c_n, v_n, z_n, s_n, is_arith;

  alu_logic_unit #(.W(W)) u_logic (
    .a(op_a), .b(op_b), .fn(func_sel), .y(lg_y)
  );

  alu_arith_unit #(.W(W)) u_arith (
    .a(op_a), .b(op_b), .cin(carry_in), .fn(func_sel),
    .sum(ar_y), .cout(ar_c), .ovr(ar_v)
  );

  assign is_arith = func_sel[FN_W-1] && (alu_fn_e'(func_sel) != FN_RSVD);

  always_comb begin
    if (is_arith) begin
      y_n = ar_y;
      c_n = ar_c;
      v_n = ar_v;
    end else begin
      y_n = lg_y;   // zero for the reserved code
      c_n = 1'b0;
      v_n = 1'b0;
    end
  end

  alu_flag_unit #(.W(W)) u_flags (
    .y(y_n), .zero(z_n), .sign(s_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      carry_out <= 1'b0;
      ovf_flag  <= 1'b0;
      zero_flag <= 1'b1;
      sign_flag <= 1'b0;
    end else begin
      result    <= y_n;
      carry_out <= c_n;
      ovf_flag  <= v_n;
      zero_flag <= z_n;
      sign_flag <= s_n;
    end
  end

  AST_LOGIC_NO_CARRY: assert property (@(posedge clk) disable iff (rst)
    !$past(func_sel[FN_W-1]) |-> (!carry_out && !ovf_flag)); // R3
  AST_RESERVED_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($past(func_sel) == FN_RSVD) |-> (result == '0 && !carry_out && !ovf_flag)); // R8
  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
    zero_flag == (result == '0)); // R9
  AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (rst)
    sign_flag == result[W-1]); // R10
endmodule

// File: tb/test_alu_seven_fn.sv
module test_alu_seven_fn;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] op_a = '0, op_b = '0;
  logic        carry_in = 1'b0;
  logic [2:0]  func_sel = '0;
  logic [15:0] result;
  logic        carry_out, zero_flag, sign_flag, ovf_flag;

  int n_checks = 0;
  int n_fail   = 0;

  alu_seven_fn i_alu_seven_fn (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .func_sel(func_sel), .result(result), .carry_out(carry_out),
    .zero_flag(zero_flag), .sign_flag(sign_flag), .ovf_flag(ovf_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // reference model from the requirements
  task automatic expect_of(input logic [15:0] a, input logic [15:0] b, input logic c,
                           input logic [2:0] f, output logic [15:0] y,
                           output logic co, output logic ov);
    int sa, sb, ci, r;
    sa = $signed(a); sb = $signed(b); ci = c ? 1 : 0;
    co = 1'b0; ov = 1'b0; y = '0;
    case (f)
      3'd0: y = a & b;
      3'd1: y = a | b;
      3'd2: y = a ^ b;
      3'd3: y = ~a;
      3'd4: begin
        r  = int'(a) + int'(b) + ci;
        y  = r[15:0]; co = (r > 65535);
        r  = sa + sb + ci; ov = (r > 32767) || (r < -32768);
      end
      3'd5: begin
        r  = int'(a) - int'(b) - ci;
        y  = r[15:0]; co = (r >= 0);
        r  = sa - sb - ci; ov = (r > 32767) || (r < -32768);
      end
      3'd6: begin
        r  = int'(b) - int'(a) - ci;
        y  = r[15:0]; co = (r >= 0);
        r  = sb - sa - ci; ov = (r > 32767) || (r < -32768);
      end
      default: ;
    endcase
  endtask

  task automatic run_op(input string tag, input logic [15:0] a, input logic [15:0] b,
                        input logic c, input logic [2:0] f);
    logic [15:0] ey; logic eco, eov;
    @(negedge clk);
    op_a = a; op_b = b; carry_in = c; func_sel = f;
    @(negedge clk);
    expect_of(a, b, c, f, ey, eco, eov);
    check({tag, " result"}, {16'h0, result}, {16'h0, ey});
    check({tag, " carry_out"}, {31'h0, carry_out}, {31'h0, eco});
    check({tag, " ovf_flag R7"}, {31'h0, ovf_flag}, {31'h0, eov});
    check({tag, " zero_flag R9"}, {31'h0, zero_flag}, {31'h0, ey == 16'h0});
    check({tag, " sign_flag R10"}, {31'h0, sign_flag}, {31'h0, ey[15]});
  endtask

  task automatic test_reset;
    rst = 1'b1;
    op_a = 16'hFFFF; op_b = 16'hFFFF; carry_in = 1'b1; func_sel = 3'd4;
    @(negedge clk); @(negedge clk);
    check("R1 reset result", {16'h0, result}, 32'h0);
    check("R1 reset carry", {31'h0, carry_out}, 32'h0);
    check("R1 reset ovf", {31'h0, ovf_flag}, 32'h0);
    check("R1 reset zero", {31'h0, zero_flag}, 32'h1);
    check("R1 reset sign", {31'h0, sign_flag}, 32'h0);
    rst = 1'b0;
  endtask

  task automatic test_logic;
    for (int f = 0; f < 4; f++) begin
      run_op("R2 R3 logic cin0", 16'hF0CC, 16'h3CAA, 1'b0, f[2:0]);
      run_op("R2 R3 logic cin1", 16'hF0CC, 16'h3CAA, 1'b1, f[2:0]);
    end
    run_op("R2 not of ones", 16'hFFFF, 16'h1234, 1'b1, 3'd3);
    run_op("R2 and zero", 16'h5555, 16'hAAAA, 1'b1, 3'd0);
  endtask

  task automatic test_add;
    run_op("R4 add plain", 16'h1234, 16'h4321, 1'b0, 3'd4);
    run_op("R4 add ripple", 16'hFFFF, 16'h0000, 1'b1, 3'd4);
    run_op("R4 R7 add pos ovf", 16'h7FFF, 16'h0001, 1'b0, 3'd4);
    run_op("R4 R7 add neg ovf", 16'h8000, 16'h8000, 1'b0, 3'd4);
  endtask

  task automatic test_sub;
    run_op("R5 sub no borrow", 16'h0005, 16'h0003, 1'b0, 3'd5);
    run_op("R5 sub borrow", 16'h0003, 16'h0005, 1'b0, 3'd5);
    run_op("R5 sub cin equal", 16'h0004, 16'h0003, 1'b1, 3'd5);
    run_op("R5 R7 sub ovf", 16'h8000, 16'h0001, 1'b0, 3'd5);
  endtask

  task automatic test_subr;
    run_op("R6 subr no borrow", 16'h0003, 16'h0005, 1'b0, 3'd6);
    run_op("R6 subr borrow", 16'h0005, 16'h0003, 1'b1, 3'd6);
    run_op("R6 R7 subr ovf", 16'h0001, 16'h8000, 1'b0, 3'd6);
    run_op("R6 R7 subr ovf2", 16'hFFFF, 16'h7FFF, 1'b0, 3'd6);
  endtask

  task automatic test_reserved;
    run_op("R8 reserved", 16'hFFFF, 16'hFFFF, 1'b1, 3'd7);
    run_op("R8 reserved2", 16'h7FFF, 16'h0001, 1'b0, 3'd7);
  endtask

  task automatic test_random;
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r0, r1;
      r0 = $urandom; r1 = $urandom;
      run_op("R1 R4 R5 R6 random", r0[15:0], r0[31:16], r1[0], r1[3:1]);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_logic();
    test_add();
    test_sub();
    test_subr();
    test_reserved();
    test_random();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule